// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a parallel NOR-style flash memory. It watches single-cycle bus writes, each one an address and an 8-bit data byte qualified by a write strobe, and decodes the data byte as a command. The decoded commands choose what the read port returns: either the word stored at the presented address or the status register. Program and block erase are two-write commands, a setup code followed by a second write. The second write starts an internal operation model that stays busy for a programmable number of clock cycles and then applies the change to a small behavioural array.

A running operation can be suspended and later resumed. The remaining count is held while the operation is suspended. The status register reports ready, the two suspended states and two sticky error bits. The error bits are set by a wrong confirm code or an invalid command, and only a clear command removes them. While an operation runs, only the status-read and suspend commands are acted on.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset the read port shows array data, every array word is 0xFF, and the status register is 0x80. Status bit positions are: bit7 ready, bit6 erase suspended, bit5 erase/sequence error, bit4 program/sequence error, bit2 program suspended. Bits 3, 1 and 0 read 0.
- R2: Writing 0xFF while no operation runs switches reads to array data: `rdata` equals the word at `addr`.
- R3: 0x40, or the alternate code 0x10, arms a program and switches reads to status. The next write starts a program of its data at its address. Ready reads 0 for exactly BUSY_CYC clock edges. After that the word holds the bitwise AND of its old value and the data.
- R4: 0x20 followed by 0xD0 starts an erase of the block selected by the upper ADDR_W-OFS_W bits of the confirm write's address. After BUSY_CYC edges, every word of that block reads 0xFF and words of other blocks are unchanged.
- R5: After 0x20, a second write other than 0xD0 sets status bits 5 and 4, switches reads to status, disarms the sequence and starts nothing.
- R6: While an operation runs, only 0x70 (read status) and 0xB0 (suspend) take effect. Any other write changes neither the read view nor the status register.
- R7: 0xB0 during a running operation sets ready to 1 and sets bit6 for an erase or bit2 for a program. It freezes the remaining count for as long as the operation stays suspended. Array reads are allowed during suspend.
- R8: 0xD0 while suspended clears the suspended bit, clears ready, switches reads to status, and finishes after exactly the count that was left at the suspend.
- R9: The reserved codes 0x00, 0x01, 0x60, 0x2F, 0xC0 and 0x98, and any other unassigned code (including 0xD0 with nothing suspended), written while idle, set status bits 5 and 4 and switch reads to status.
- R10: 0x70 switches reads to status. 0x50 written while idle clears status bits 5, 4 and 3 and leaves the read view unchanged. The error bits stay set until 0x50 is written.
- R11: A suspend written on the edge at which the count finishes is not taken. The operation completes, and ready reads 1 with both suspended bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Bus write strobe, one write per cycle high |
| addr | input | ADDR_W | Word address for writes and reads |
| wdata | input | 8 | Command or program data byte |
| rdata | output | 8 | Array word at `addr` or status register, by read view |

## Verification
Two functions can land on the same edge. One is the end of the busy countdown, which writes the array and raises ready. The other is a suspend command, which tries to freeze that same countdown. The bench starts a program, waits exactly one cycle fewer than the busy length, and then issues 0xB0 so that the strobe is sampled on the finishing edge. The case passes if the status then reads 0x80 with no suspended bit and the word afterwards holds the programmed value.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_PROG_ALT    = 8'h10;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
    localparam logic [7:0] CMD_READ_STAT   = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT    = 8'h50;

    typedef enum logic {VIEW_ARRAY, VIEW_STATUS} view_t;
    typedef enum logic [1:0] {ARM_NONE, ARM_PROG, ARM_ERASE} arm_t;
    typedef enum logic [1:0] {JOB_NONE, JOB_PROG, JOB_ERASE} job_t;

    typedef struct packed {
        logic ready;
        logic erase_susp;
        logic err_erase;
        logic err_prog;
        logic err_volt;
        logic prog_susp;
        logic [1:0] rsvd;
    } status_t;

    function automatic status_t make_status(logic busy, logic es, logic e5,
                                            logic e4, logic ps);
        status_t s;
        s.ready      = ~busy;
        s.erase_susp = es;
        s.err_erase  = e5;
        s.err_prog   = e4;
        s.err_volt   = 1'b0;
        s.prog_susp  = ps;
        s.rsvd       = 2'b00;
        return s;
    endfunction

endpackage

// File: rtl/flash_wsm.sv
module flash_wsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 16,
    parameter int BUSY_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  job_t              start_kind,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    input  logic              suspend,
    input  logic              resume,
    output logic              running,
    output logic              susp_erase,
    output logic              susp_prog,
    output logic              finish,
    output job_t              job_kind,
    output logic [ADDR_W-1:0] job_addr,
    output logic [7:0]        job_data
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYC);

    logic             suspended;
    logic [CNT_W-1:0] cnt;

    assign finish     = running && (cnt == CNT_W'(1));
    assign susp_erase = suspended && (job_kind == JOB_ERASE);
    assign susp_prog  = suspended && (job_kind == JOB_PROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            suspended <= 1'b0;
            cnt       <= '0;
            job_kind  <= JOB_NONE;
            job_addr  <= '0;
            job_data  <= '0;
        end else if (start) begin
            running   <= 1'b1;
            suspended <= 1'b0;
            cnt       <= LOAD;
            job_kind  <= start_kind;
            job_addr  <= start_addr;
            job_data  <= start_data;
        end else if (running) begin
            if (cnt == CNT_W'(1)) begin
                running <= 1'b0;
            end else if (suspend) begin
                running   <= 1'b0;
                suspended <= 1'b1;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end else if (suspended && resume) begin
            running   <= 1'b1;
            suspended <= 1'b0;
        end
    end

    AST_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
        running |-> cnt != '0);                                       // R3
    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        suspended && !resume && !start |=> suspended && $stable(cnt)); // R7
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(running && suspended));                                     // R7
    AST_FINISH_WINS: assert property (@(posedge clk) disable iff (rst)
        finish && !start |=> !running && !suspended);                 // R11

endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFS_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wr_go,
    input  job_t              wr_kind,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int BLK_WORDS = 1 << OFS_W;
    localparam int BLK_W     = ADDR_W - OFS_W;

    logic [7:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_go) begin
            if (wr_kind == JOB_PROG) begin
                mem[wr_addr] <= mem[wr_addr] & wr_data;
            end else if (wr_kind == JOB_ERASE) begin
                for (int b = 0; b < BLK_WORDS; b++)
                    mem[{wr_addr[ADDR_W-1:OFS_W], OFS_W'(b)}] <= 8'hFF;
            end
        end
    end

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (rst)
        wr_go && wr_kind == JOB_PROG |=>
        (mem[$past(wr_addr)] & ~$past(mem[wr_addr])) == 8'h00);       // R3
    AST_ERASE_BASE: assert property (@(posedge clk) disable iff (rst)
        wr_go && wr_kind == JOB_ERASE |=>
        mem[{$past(wr_addr[ADDR_W-1:OFS_W]), OFS_W'(0)}] == 8'hFF);    // R4

    logic [BLK_W-1:0] unused_blk;
    assign unused_blk = '0;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int OFS_W    = 4,
    parameter int CNT_W    = 16,
    parameter int BUSY_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    view_t   view, nxt_view;
    arm_t    arm, nxt_arm;
    logic    err_hi, err_lo;
    logic    set_err, clr_err;
    logic    start, suspend, resume;
    job_t    start_kind;
    logic    running, susp_erase, susp_prog, finish;
    job_t    job_kind;
    logic [ADDR_W-1:0] job_addr;
    logic [7:0]        job_data, arr_data;
    status_t status;
    logic    suspended;

    assign suspended = susp_erase || susp_prog;
    assign status    = make_status(running, susp_erase, err_hi, err_lo, susp_prog);
    assign rdata     = (view == VIEW_ARRAY) ? arr_data : status;

    always_comb begin
        nxt_view   = view;
        nxt_arm    = arm;
        set_err    = 1'b0;
        clr_err    = 1'b0;
        start      = 1'b0;
        start_kind = JOB_NONE;
        suspend    = 1'b0;
        resume     = 1'b0;
        if (wr_stb) begin
            if (running) begin
                if (wdata == CMD_READ_STAT) begin
                    nxt_view = VIEW_STATUS;
                end else if (wdata == CMD_SUSPEND) begin
                    suspend  = 1'b1;
                    nxt_view = VIEW_STATUS;
                end
            end else if (arm == ARM_PROG) begin
                start      = 1'b1;
                start_kind = JOB_PROG;
                nxt_arm    = ARM_NONE;
                nxt_view   = VIEW_STATUS;
            end else if (arm == ARM_ERASE) begin
                nxt_arm  = ARM_NONE;
                nxt_view = VIEW_STATUS;
                if (wdata == CMD_CONFIRM) begin
                    start      = 1'b1;
                    start_kind = JOB_ERASE;
                end else begin
                    set_err = 1'b1;
                end
            end else begin
                case (wdata)
                    CMD_READ_ARRAY: nxt_view = VIEW_ARRAY;
                    CMD_READ_STAT:  nxt_view = VIEW_STATUS;
                    CMD_CLR_STAT:   clr_err  = 1'b1;
                    CMD_SUSPEND:    ;
                    CMD_PROG_SETUP, CMD_PROG_ALT: begin
                        if (!suspended) begin
                            nxt_arm  = ARM_PROG;
                            nxt_view = VIEW_STATUS;
                        end
                    end
                    CMD_ERASE_SETUP: begin
                        if (!suspended) begin
                            nxt_arm  = ARM_ERASE;
                            nxt_view = VIEW_STATUS;
                        end
                    end
                    CMD_CONFIRM: begin
                        nxt_view = VIEW_STATUS;
                        if (suspended) resume  = 1'b1;
                        else           set_err = 1'b1;
                    end
                    default: begin
                        set_err  = 1'b1;
                        nxt_view = VIEW_STATUS;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            view   <= VIEW_ARRAY;
            arm    <= ARM_NONE;
            err_hi <= 1'b0;
            err_lo <= 1'b0;
        end else begin
            view <= nxt_view;
            arm  <= nxt_arm;
            if (set_err) begin
                err_hi <= 1'b1;
                err_lo <= 1'b1;
            end else if (clr_err) begin
                err_hi <= 1'b0;
                err_lo <= 1'b0;
            end
        end
    end

    flash_wsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUSY_CYC(BUSY_CYC)) u_wsm (
        .clk(clk), .rst(rst),
        .start(start), .start_kind(start_kind),
        .start_addr(addr), .start_data(wdata),
        .suspend(suspend), .resume(resume),
        .running(running), .susp_erase(susp_erase), .susp_prog(susp_prog),
        .finish(finish), .job_kind(job_kind),
        .job_addr(job_addr), .job_data(job_data)
    );

    flash_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_array (
        .clk(clk), .rst(rst),
        .rd_addr(addr), .rd_data(arr_data),
        .wr_go(finish), .wr_kind(job_kind),
        .wr_addr(job_addr), .wr_data(job_data)
    );

    AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (rst)
        wr_stb && arm == ARM_ERASE && wdata != CMD_CONFIRM |=>
        rdata[5:4] == 2'b11 && view == VIEW_STATUS && !running);      // R5
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        wr_stb && running && wdata != CMD_READ_STAT && wdata != CMD_SUSPEND |=>
        $stable(view) && $stable({err_hi, err_lo}));                  // R6
    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !running && !suspended);                            // R3
    AST_CLEAR_ERR: assert property (@(posedge clk) disable iff (rst)
        wr_stb && !running && arm == ARM_NONE && wdata == CMD_CLR_STAT |=>
        status[5:3] == 3'b000);                                       // R10
    AST_SUSPEND_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $countones({running, susp_erase, susp_prog}) <= 1);           // R7

endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
    localparam int AW = 6;
    localparam int N  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .OFS_W(3), .CNT_W(8), .BUSY_CYC(N)) i_flash_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(addr),
        .wdata(wdata), .rdata(rdata)
    );

    // {command, address, expected rdata, requirement number}
    localparam int NV = 13;
    localparam logic [31:0] VEC [NV] = '{
        {8'h70, 8'd0, 8'h80, 8'd10},   // R10 status view
        {8'h00, 8'd0, 8'hB0, 8'd9},    // R9 reserved
        {8'h50, 8'd0, 8'h80, 8'd10},   // R10 clear
        {8'h98, 8'd0, 8'hB0, 8'd9},    // R9 reserved
        {8'hFF, 8'd3, 8'hFF, 8'd2},    // R2 array view
        {8'h50, 8'd0, 8'hFF, 8'd10},   // R10 clear keeps array view
        {8'h70, 8'd0, 8'h80, 8'd10},   // R10 status shows cleared bits
        {8'h20, 8'd0, 8'h80, 8'd5},    // R5 setup
        {8'h55, 8'd0, 8'hB0, 8'd5},    // R5 wrong confirm
        {8'h50, 8'd0, 8'h80, 8'd10},   // R10
        {8'h2F, 8'd0, 8'hB0, 8'd9},    // R9 reserved
        {8'h50, 8'd0, 8'h80, 8'd10},   // R10
        {8'hFF, 8'd1, 8'hFF, 8'd2}     // R2
    };

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        addr   = a;
        wdata  = d;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic chk(input string req, input logic [7:0] exp);
        #1;
        total++;
        if (rdata !== exp) begin
            bad++;
            $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req, input logic [7:0] exp);
        addr = a;
        chk(req, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        rd(0, "R1 array after reset", 8'hFF);
        wr(0, 8'h70); chk("R1 status after reset", 8'h80);

        for (int i = 0; i < NV; i++) begin
            wr(AW'(VEC[i][23:16]), VEC[i][31:24]);
            chk($sformatf("R%0d vector %0d", VEC[i][7:0], i), VEC[i][15:8]);
        end

        // R3 program
        wr(0, 8'h40);  chk("R3 setup shows status", 8'h80);
        wr(9, 8'h3C);  chk("R3 busy", 8'h00);
        idle(N - 1);   chk("R3 busy last cycle", 8'h00);
        idle(1);       chk("R3 ready", 8'h80);
        wr(9, 8'hFF);  chk("R3 programmed word", 8'h3C);
        wr(0, 8'h10);  wr(9, 8'hF0); idle(N);
        chk("R3 alternate code done", 8'h80);
        wr(9, 8'hFF);  chk("R3 AND result", 8'h30);
        wr(0, 8'h40);  wr(17, 8'h12); idle(N);

        // R4 R6 R7 R8 erase with suspend
        wr(0, 8'h00);  chk("R9 error set", 8'hB0);
        wr(0, 8'h20);  wr(10, 8'hD0); chk("R4 erase busy", 8'h30);
        wr(0, 8'h50);  chk("R6 clear ignored", 8'h30);
        wr(0, 8'hFF);  chk("R6 array ignored", 8'h30);
        wr(0, 8'hB0);  chk("R7 erase suspended", 8'hF0);
        idle(20);      chk("R7 still suspended", 8'hF0);
        wr(9, 8'hFF);  chk("R7 array read in suspend", 8'h30);
        wr(0, 8'hD0);  chk("R8 resumed", 8'h30);
        idle(N - 3);   chk("R8 remaining count", 8'h30);
        idle(1);       chk("R8 done", 8'hB0);
        wr(0, 8'h50);  chk("R10 clear", 8'h80);
        wr(9, 8'hFF);  chk("R4 erased word", 8'hFF);
        rd(8,  "R4 block start", 8'hFF);
        rd(15, "R4 block end", 8'hFF);
        rd(17, "R4 other block kept", 8'h12);

        // R7 R8 program suspend
        wr(0, 8'h40);  wr(20, 8'h0F);
        wr(0, 8'hB0);  chk("R7 program suspended", 8'h84);
        wr(0, 8'h40);  chk("R7 setup ignored in suspend", 8'h84);
        wr(0, 8'hD0);  chk("R8 program resumed", 8'h00);
        idle(N);       chk("R8 program done", 8'h80);
        wr(20, 8'hFF); chk("R8 program result", 8'h0F);

        // R11 suspend on finishing edge
        wr(0, 8'h40);  wr(21, 8'h5A);
        idle(N - 1);
        wr(0, 8'hB0);  chk("R11 finish beats suspend", 8'h80);
        wr(21, 8'hFF); chk("R11 word written", 8'h5A);

        // R1 reset again
        wr(0, 8'h70);
        rst = 1'b1; idle(1); rst = 1'b0;
        rd(21, "R1 reset clears array", 8'hFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule